// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Split HI/LO Accumulator

This unit sits beside the integer pipeline of a 64-bit core. It multiplies two signed 16-bit operands and adds the product into a 64-bit running sum. The operands are the low halfwords of two 64-bit source register values. The running sum is held as two 32-bit word registers, HI for the upper word and LO for the lower word. Software can also load either word directly through its own write port, for example to preset or clear the accumulator before a run of accumulations.

The sum wraps modulo 2^64 and no overflow is ever signalled. When HI and LO are presented on the 64-bit datapath, each word is sign-extended. A flag is raised with the done strobe when either operand's upper bits are not a proper copy of its halfword sign bit. This flag is only a diagnostic: the arithmetic always uses bits 15:0 of each operand.

Top module: `mac_hilo`

## Requirements
- R1: On an issue, the signed product of opA[15:0] and opB[15:0], sign-extended to 64 bits, is added to the 64-bit value {HI,LO}.
- R2: The low 32 bits of the sum are written to LO and the high 32 bits are written to HI.
- R3: The sum wraps modulo 2^64. No overflow indication exists, so carrying out of bit 63 is silently dropped.
- R4: Operand bits 63:16 have no effect on HI or LO.
- R5: badSignExt is high in the done cycle exactly when bits 63:15 of opA or of opB are not all equal. Outside done cycles it is low.
- R6: HI and LO take their new values at the clock edge that samples issue. done is high for exactly the one cycle after each issue cycle, including during back-to-back issues.
- R7: hiWrEn loads HI from hiWrData and loWrEn loads LO from loWrData, each independently, at the next edge. The other word is unchanged.
- R8: When issue and a direct write fall in the same cycle, the accumulate result is stored and the write data is discarded.
- R9: A synchronous active-high reset clears HI, LO, done and badSignExt to zero.
- R10: hiOut and loOut present HI and LO sign-extended from bit 31 to 64 bits.
- R11: With no issue and no write, HI and LO hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue | input | 1 | Start one multiply-accumulate |
| opA | input | 64 | First source operand, low halfword used |
| opB | input | 64 | Second source operand, low halfword used |
| hiWrEn | input | 1 | Direct load of HI |
| hiWrData | input | 32 | Data for HI load |
| loWrEn | input | 1 | Direct load of LO |
| loWrData | input | 32 | Data for LO load |
| hiOut | output | 64 | HI, sign-extended |
| loOut | output | 64 | LO, sign-extended |
| done | output | 1 | One-cycle pulse after an issue |
| badSignExt | output | 1 | Operand upper bits were not a sign extension |

## Verification
A vector table covers operand pairs with every combination of signs. It includes the extreme pair -32768 x -32768, which tells a true signed multiplier from one that truncates or multiplies unsigned, and it accumulates the vectors back to back to expose carries from LO into HI. Preset accumulators near the positive and unsigned limits separate correct 64-bit wraparound from a saturating or 32-bit sum, and they also show the sign extension of HI on read-out. Operands with garbage upper bits show that the arithmetic ignores them while the flag reports them. Collisions between writes and issues, and idle cycles, check the priority rule and the hold behaviour.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef struct packed {
    logic accEn;
    logic hiLoad;
    logic loLoad;
  } ctlStrobes_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  issue,
  input  logic                  hiWrEn,
  input  logic                  loWrEn,
  output mac_pkg::ctlStrobes_t  ctl,
  output logic                  done
);
  always_comb begin
    ctl.accEn  = issue;
    ctl.hiLoad = hiWrEn & ~issue;
    ctl.loLoad = loWrEn & ~issue;
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= issue;
  end

  // R8: a direct load never coexists with an accumulate
  assert_acc_priority_R8: assert property (@(posedge clk) disable iff (rst)
    ctl.accEn |-> !(ctl.hiLoad || ctl.loLoad));
  // R6: done follows issue by one cycle
  assert_done_follows_R6: assert property (@(posedge clk) disable iff (rst)
    issue |=> done);
  assert_done_only_R6: assert property (@(posedge clk) disable iff (rst)
    !issue |=> !done);
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int OPW = 16,
  parameter int WW  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  mac_pkg::ctlStrobes_t  ctl,
  input  logic [2*WW-1:0]       opA,
  input  logic [2*WW-1:0]       opB,
  input  logic [WW-1:0]         hiWrData,
  input  logic [WW-1:0]         loWrData,
  output logic [WW-1:0]         hiReg,
  output logic [WW-1:0]         loReg,
  output logic                  badFlag
);
  localparam int DW  = 2 * WW;
  localparam int PW  = 2 * OPW;
  localparam int TOP = DW - OPW + 1;

  logic signed [OPW-1:0] aHalf, bHalf;
  logic signed [PW-1:0]  prod;
  logic [DW-1:0]         prodExt, sum;
  logic [TOP-1:0]        aUpper, bUpper;
  logic                  aBad, bBad;

  always_comb begin
    aHalf   = opA[OPW-1:0];
    bHalf   = opB[OPW-1:0];
    prod    = aHalf * bHalf;
    prodExt = {{(DW-PW){prod[PW-1]}}, prod};
    sum     = {hiReg, loReg} + prodExt;
    aUpper  = opA[DW-1:OPW-1];
    bUpper  = opB[DW-1:OPW-1];
    aBad    = ~((&aUpper) | ~(|aUpper));
    bBad    = ~((&bUpper) | ~(|bUpper));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hiReg   <= '0;
      loReg   <= '0;
      badFlag <= 1'b0;
    end else begin
      badFlag <= ctl.accEn & (aBad | bBad);
      if (ctl.accEn) begin
        hiReg <= sum[DW-1:WW];
        loReg <= sum[WW-1:0];
      end else begin
        if (ctl.hiLoad) hiReg <= hiWrData;
        if (ctl.loLoad) loReg <= loWrData;
      end
    end
  end

  // R9: reset clears the accumulator words
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (hiReg == '0 && loReg == '0 && !badFlag));
  // R11: idle cycles hold the accumulator
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !(ctl.accEn || ctl.hiLoad || ctl.loLoad) |=> ($stable(hiReg) && $stable(loReg)));
  // R7: a lone LO load leaves HI alone and vice versa
  assert_lo_only_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl.loLoad && !ctl.hiLoad) |=> ($stable(hiReg) && loReg == $past(loWrData)));
  assert_hi_only_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl.hiLoad && !ctl.loLoad) |=> ($stable(loReg) && hiReg == $past(hiWrData)));
endmodule

// File: rtl/mac_hilo.sv
module mac_hilo #(
  parameter int OPW = 16,
  parameter int WW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [2*WW-1:0]   opA,
  input  logic [2*WW-1:0]   opB,
  input  logic              hiWrEn,
  input  logic [WW-1:0]     hiWrData,
  input  logic              loWrEn,
  input  logic [WW-1:0]     loWrData,
  output logic [2*WW-1:0]   hiOut,
  output logic [2*WW-1:0]   loOut,
  output logic              done,
  output logic              badSignExt
);
  localparam int DW = 2 * WW;

  mac_pkg::ctlStrobes_t ctl;
  logic [WW-1:0] hiReg, loReg;
  logic          badFlag;

  mac_ctrl i_ctrl (
    .clk(clk), .rst(rst), .issue(issue), .hiWrEn(hiWrEn), .loWrEn(loWrEn),
    .ctl(ctl), .done(done)
  );

  mac_datapath #(.OPW(OPW), .WW(WW)) i_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .opA(opA), .opB(opB),
    .hiWrData(hiWrData), .loWrData(loWrData),
    .hiReg(hiReg), .loReg(loReg), .badFlag(badFlag)
  );

  always_comb begin
    hiOut      = {{WW{hiReg[WW-1]}}, hiReg};
    loOut      = {{WW{loReg[WW-1]}}, loReg};
    badSignExt = badFlag;
  end

  function automatic logic [DW-1:0] refProd(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    logic signed [2*OPW-1:0] p;
    p = $signed(a) * $signed(b);
    return {{(DW-2*OPW){p[2*OPW-1]}}, p};
  endfunction

  // R1 R2 R3: the word pair grows by the signed product, modulo 2^64
  assert_acc_step_R1: assert property (@(posedge clk) disable iff (rst)
    issue |=> (({hiOut[WW-1:0], loOut[WW-1:0]} - $past({hiOut[WW-1:0], loOut[WW-1:0]}))
               == refProd($past(opA[OPW-1:0]), $past(opB[OPW-1:0]))));
  // R5: the flag only appears with done
  assert_flag_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    badSignExt |-> done);
endmodule

// File: tb/test_mac_hilo.sv
`timescale 1ns/1ps
module test_mac_hilo;
  logic        clk = 1'b0;
  logic        rst, issue, hiWrEn, loWrEn;
  logic [63:0] opA, opB;
  logic [31:0] hiWrData, loWrData;
  logic [63:0] hiOut, loOut;
  logic        done, badSignExt;

  int checks = 0;
  int errors = 0;
  logic [63:0] model = '0;

  always #2.5 clk = ~clk;

  mac_hilo i_mac_hilo (
    .clk(clk), .rst(rst), .issue(issue), .opA(opA), .opB(opB),
    .hiWrEn(hiWrEn), .hiWrData(hiWrData), .loWrEn(loWrEn), .loWrData(loWrData),
    .hiOut(hiOut), .loOut(loOut), .done(done), .badSignExt(badSignExt)
  );

  localparam int NV = 8;
  localparam logic [63:0] VEC_A [NV] = '{
    64'd3, 64'hFFFF_FFFF_FFFF_FFFE, 64'd32767, 64'hFFFF_FFFF_FFFF_8000,
    64'hFFFF_FFFF_FFFF_8000, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1000 };
  localparam logic [63:0] VEC_B [NV] = '{
    64'd5, 64'd7, 64'd32767, 64'hFFFF_FFFF_FFFF_8000,
    64'd32767, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FED4 };
  localparam logic [63:0] VEC_P [NV] = '{
    64'd15, 64'hFFFF_FFFF_FFFF_FFF2, 64'h0000_0000_3FFF_0001, 64'h0000_0000_4000_0000,
    64'hFFFF_FFFF_C000_8000, 64'd0, 64'd1, 64'hFFFF_FFFF_FFFB_6C20 };

  function automatic logic [63:0] sx(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkState(input string tag);
    chk({tag, " hiOut"}, hiOut, sx(model[63:32]));
    chk({tag, " loOut"}, loOut, sx(model[31:0]));
  endtask

  task automatic idle();
    issue = 0; hiWrEn = 0; loWrEn = 0;
  endtask

  task automatic doMac(input logic [63:0] a, input logic [63:0] b, input logic [63:0] p,
                       input logic bad, input string tag);
    @(negedge clk);
    issue = 1; opA = a; opB = b;
    @(negedge clk);
    idle();
    model = model + p;
    chk({tag, " done"}, {63'd0, done}, 64'd1);
    chk({tag, " flag"}, {63'd0, badSignExt}, {63'd0, bad});
    chkState(tag);
  endtask

  task automatic writeRegs(input logic we_hi, input logic [31:0] h,
                           input logic we_lo, input logic [31:0] l);
    @(negedge clk);
    hiWrEn = we_hi; hiWrData = h; loWrEn = we_lo; loWrData = l;
    @(negedge clk);
    idle();
    if (we_hi) model[63:32] = h;
    if (we_lo) model[31:0]  = l;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; idle(); opA = '0; opB = '0; hiWrData = '0; loWrData = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset hiOut", hiOut, 64'd0);
    chk("R9 reset loOut", loOut, 64'd0);
    chk("R9 reset done", {63'd0, done}, 64'd0);
    chk("R9 reset flag", {63'd0, badSignExt}, 64'd0);
    rst = 0;
    @(negedge clk);

    // R1 R2 R6: table walked back to back
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      issue = 1; opA = VEC_A[i]; opB = VEC_B[i];
      @(negedge clk);
      model = model + VEC_P[i];
      chk($sformatf("R6 vec%0d done", i), {63'd0, done}, 64'd1);
      chk($sformatf("R1 vec%0d flag", i), {63'd0, badSignExt}, 64'd0);
      chkState($sformatf("R2 vec%0d", i));
    end
    idle();
    @(negedge clk);
    chk("R6 done drops", {63'd0, done}, 64'd0);

    // R11: hold over idle cycles
    repeat (4) @(negedge clk);
    chkState("R11 hold");

    // R7: independent writes
    writeRegs(1, 32'h1234_5678, 0, 32'hAAAA_AAAA);
    chkState("R7 hi only");
    writeRegs(0, 32'h5555_5555, 1, 32'h8765_4321);
    chkState("R7 lo only");
    chk("R10 lo sign-extended", loOut, 64'hFFFF_FFFF_8765_4321);

    // R3: wraparound past 2^64
    writeRegs(1, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF);
    doMac(64'd1, 64'd1, 64'd1, 0, "R3 wrap to zero");
    chk("R3 zero", {hiOut[31:0], loOut[31:0]}, 64'd0);
    // R10: carry into HI sign bit shows on read-out
    writeRegs(1, 32'h7FFF_FFFF, 1, 32'hFFFF_FFFF);
    doMac(64'd1, 64'd1, 64'd1, 0, "R10 carry");
    chk("R10 hi sign-extended", hiOut, 64'hFFFF_FFFF_8000_0000);
    // R3: negative product across zero borrows through HI
    writeRegs(1, 32'h0, 1, 32'h0);
    doMac(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R3 borrow");

    // R4 R5: garbage upper bits ignored in arithmetic, flagged
    doMac(64'h1234_0000_0000_0003, 64'd2, 64'd6, 1, "R4 R5 upperA");
    doMac(64'd4, 64'h0000_0000_0000_8000, 64'hFFFF_FFFF_FFFE_0000, 1, "R4 R5 bit15 only");
    doMac(64'hFFFF_FFFF_FFFF_8000, 64'hFFFF_FFFF_FFFF_8000, 64'h4000_0000, 0, "R5 clean minmin");

    // R8: accumulate wins over simultaneous writes
    @(negedge clk);
    issue = 1; opA = 64'd10; opB = 64'd10;
    hiWrEn = 1; hiWrData = 32'hDEAD_BEEF; loWrEn = 1; loWrData = 32'hCAFE_F00D;
    @(negedge clk);
    idle();
    model = model + 64'd100;
    chkState("R8 priority");

    // R9: reset in mid-run
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    model = '0;
    chkState("R9 mid reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule